// File: doc/BRIEF.md
# Radix-4 SRT Mantissa Divider

This block divides one normalized fixed-point mantissa by another. Both operands have one integer bit and `MW-1` fraction bits, with the integer bit set, so each lies in [1,2). The dividend enters the recurrence pre-scaled by one quarter. Each quotient digit is taken from {-2,-1,0,+1,+2}, so the divisor multiple needed at every step is either zero, the divisor, or the divisor shifted left by one. The partial remainder is kept as a carry-save pair and never carry-propagated while the iteration runs.

A digit is chosen from an 8-bit estimate of four times the remainder. This estimate has four integer bits and four fraction bits. It is formed by a short add of the top bits of both carry-save words. It is then folded to a non-negative magnitude by inverting its bits under the sign. The magnitude is compared with two thresholds computed from the top four divisor fraction bits, and the remainder sign gives the digit its sign. `S` such steps are chained inside one clock. After `ITERS = ceil(MW/(2*S))` iteration cycles, a single extra cycle does three things. It resolves the remainder with a full-width add. It subtracts the negative-digit register from the positive-digit register. If the resolved remainder is negative, it corrects the quotient down by one and the remainder up by the divisor.

The controller has three states. In IDLE it waits for `start`: IDLE goes to RUN on `start`. In RUN it retires `2*S` quotient bits per cycle: RUN goes to FIX after `ITERS` cycles. In FIX it performs the final resolution and correction: FIX always returns to IDLE and pulses `done`.

Top module: `srt_div`

## Requirements
- R1: While reset is applied, and after it is released, `busy` and `done` are low and `quo` and `rem` read zero until the first operation completes.
- R2: A `start` seen in IDLE raises `busy` on the next cycle. `busy` then stays high for exactly `ITERS+1` cycles, where `ITERS = ceil(MW/(2*S))`.
- R3: `done` is high for exactly one cycle. This is the first cycle in which `busy` is low again.
- R4: With `ND = S*ITERS` digits, `quo` equals floor(dividend * 4^(ND-1) / divisor), with the operands read as unsigned integers.
- R5: `rem` equals dividend * 4^(ND-1) - quo * divisor, and 0 <= rem < divisor.
- R6: `rem_neg` is 1 when the resolved carry-save remainder was negative and was corrected. Because the uncorrected remainder stays within two thirds of the divisor, rem_neg=1 implies 3*rem >= divisor, and rem_neg=0 implies 3*rem <= 2*divisor.
- R7: A `start` while `busy` is high is ignored. The running operation keeps its operands and its length.
- R8: `quo`, `rem` and `rem_neg` hold their values in every cycle except the `done` cycle.
- R9: Equal dividend and divisor give `quo` = 4^(ND-1) and `rem` = 0. This holds at the extremes of the divisor range as well: exactly 1.0, and the value just below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division with the present operands (taken in IDLE only) |
| dividend | input | MW | Dividend mantissa, integer bit set |
| divisor | input | MW | Divisor mantissa, integer bit set |
| busy | output | 1 | High from the cycle after an accepted start until the result is ready |
| done | output | 1 | One-cycle pulse when the result is valid |
| quo | output | 2*S*ITERS | Corrected quotient |
| rem | output | MW | Non-negative remainder |
| rem_neg | output | 1 | Resolved remainder was negative and was corrected |

## Verification
The bench builds the block with `MW=20` and `S=3`. With these values, three selection-and-CSA steps are chained in one clock. The digit count (12) also overshoots the mantissa width, which exercises the rounded-up iteration count and a quotient wider than the operands. The small width lets the bench compute the exact quotient and remainder with plain wide integer division for every operand pair. This covers a divisor of exactly 1.0, the largest divisor, equal operands and random pairs. The remainder bound also shows whether the digit selection ever let the carry-save remainder leave its allowed band.

// File: rtl/srt_pkg.sv
package srt_pkg;

    // Remainder estimate: four integer bits (sign included) and four fraction bits.
    localparam int EST_W = 8;
    // Divisor fraction bits that steer the selection thresholds.
    localparam int DFR_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } srt_state_e;

    // Signed quotient digit: magnitude 0..2 with a separate sign.
    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } srt_digit_t;

endpackage

// File: rtl/srt_qsel.sv
module srt_qsel
    import srt_pkg::*;
(
    input  logic [EST_W-1:0] s_top,
    input  logic [EST_W-1:0] c_top,
    input  logic [DFR_W-1:0] dfrac,
    output srt_digit_t       dig
);

    logic [EST_W-1:0] est;
    logic             sgn;
    logic [EST_W-2:0] fold;
    logic [EST_W-1:0] t_one;
    logic [EST_W-1:0] t_two;

    // Thresholds in 1/16 units for divisor 1 + j/16:
    //   one : ceil((20 + j) / 3)
    //   two : ceil((71 + 4j) / 3)
    // These leave room for the truncation of both carry-save words
    // and for the one-sixteenth offset that the bit-inversion fold adds
    // on the negative side.
    always_comb begin
        est   = s_top + c_top;
        sgn   = est[EST_W-1];
        fold  = est[EST_W-2:0] ^ {(EST_W-1){sgn}};
        t_one = (EST_W'(22) + EST_W'(dfrac)) / EST_W'(3);
        t_two = (EST_W'(73) + (EST_W'(dfrac) << 2)) / EST_W'(3);
        if (EST_W'(fold) >= t_two) begin
            dig.mag = 2'd2;
        end else if (EST_W'(fold) >= t_one) begin
            dig.mag = 2'd1;
        end else begin
            dig.mag = 2'd0;
        end
        dig.neg = sgn && (dig.mag != 2'd0);
    end

endmodule

// File: rtl/srt_stage.sv
module srt_stage
    import srt_pkg::*;
#(
    parameter int RW = 61
) (
    input  logic [RW-1:0]    s_i,
    input  logic [RW-1:0]    c_i,
    input  logic [RW-1:0]    dv_i,
    input  logic [DFR_W-1:0] dfrac_i,
    output logic [RW-1:0]    s_o,
    output logic [RW-1:0]    c_o,
    output srt_digit_t       dig_o
);

    logic [RW-1:0] s4;
    logic [RW-1:0] c4;
    logic [RW-1:0] mult;
    logic [RW-1:0] op;
    logic [RW-1:0] maj;
    logic          cin;

    assign s4 = s_i << 2;
    assign c4 = c_i << 2;

    srt_qsel u_qsel (
        .s_top (s4[RW-1 -: EST_W]),
        .c_top (c4[RW-1 -: EST_W]),
        .dfrac (dfrac_i),
        .dig   (dig_o)
    );

    always_comb begin
        unique case (dig_o.mag)
            2'd2:    mult = dv_i << 1;
            2'd1:    mult = dv_i;
            default: mult = '0;
        endcase
        if (dig_o.mag == 2'd0) begin
            op  = '0;
            cin = 1'b0;
        end else if (dig_o.neg) begin
            op  = mult;
            cin = 1'b0;
        end else begin
            op  = ~mult;
            cin = 1'b1;
        end
        maj = (s4 & c4) | (s4 & op) | (c4 & op);
    end

    assign s_o = s4 ^ c4 ^ op;
    assign c_o = (maj << 1) | RW'(cin);

endmodule

// File: rtl/srt_div.sv
module srt_div
    import srt_pkg::*;
#(
    parameter  int MW    = 56,
    parameter  int S     = 4,
    localparam int ITERS = (MW + 2 * S - 1) / (2 * S),
    localparam int QW    = 2 * S * ITERS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] dividend,
    input  logic [MW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [QW-1:0] quo,
    output logic [MW-1:0] rem,
    output logic          rem_neg
);

    localparam int RW = MW + 5;
    localparam int CW = $clog2(ITERS + 1);

    srt_state_e    state;
    srt_state_e    nxt;
    logic [CW-1:0] cnt;
    logic [RW-1:0] s_q;
    logic [RW-1:0] c_q;
    logic [MW-1:0] d_q;
    logic [QW-1:0] qp_q;
    logic [QW-1:0] qn_q;

    logic [RW-1:0]    dv;
    logic [DFR_W-1:0] dfrac;

    assign dv    = RW'(d_q) << 2;
    assign dfrac = d_q[MW-2 -: DFR_W];

    logic [RW-1:0] s_ch  [0:S];
    logic [RW-1:0] c_ch  [0:S];
    logic [QW-1:0] qp_ch [0:S];
    logic [QW-1:0] qn_ch [0:S];
    srt_digit_t    dg    [0:S-1];

    assign s_ch[0]  = s_q;
    assign c_ch[0]  = c_q;
    assign qp_ch[0] = qp_q;
    assign qn_ch[0] = qn_q;

    for (genvar g = 0; g < S; g++) begin : g_step
        srt_stage #(.RW(RW)) u_stage (
            .s_i     (s_ch[g]),
            .c_i     (c_ch[g]),
            .dv_i    (dv),
            .dfrac_i (dfrac),
            .s_o     (s_ch[g+1]),
            .c_o     (c_ch[g+1]),
            .dig_o   (dg[g])
        );
        assign qp_ch[g+1] = (qp_ch[g] << 2) | QW'(dg[g].neg ? 2'd0 : dg[g].mag);
        assign qn_ch[g+1] = (qn_ch[g] << 2) | QW'(dg[g].neg ? dg[g].mag : 2'd0);
    end

    // Final resolution: full-width adds and the correction step.
    logic [RW-1:0] r_full;
    logic          r_neg;
    logic [RW-1:0] r_sh;
    logic [RW-1:0] rem_w;
    logic [QW-1:0] q_fix;

    always_comb begin
        r_full = s_q + c_q;
        r_neg  = r_full[RW-1];
        r_sh   = RW'($signed(r_full) >>> 2);
        rem_w  = r_neg ? (r_sh + RW'(d_q)) : r_sh;
        q_fix  = (qp_q - qn_q) - QW'(r_neg);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_RUN;
            ST_RUN:  if (cnt == CW'(ITERS - 1)) nxt = ST_FIX;
            ST_FIX:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            s_q     <= '0;
            c_q     <= '0;
            d_q     <= '0;
            qp_q    <= '0;
            qn_q    <= '0;
            done    <= 1'b0;
            quo     <= '0;
            rem     <= '0;
            rem_neg <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        s_q  <= RW'(dividend);
                        c_q  <= '0;
                        d_q  <= divisor;
                        qp_q <= '0;
                        qn_q <= '0;
                        cnt  <= '0;
                    end
                end
                ST_RUN: begin
                    s_q  <= s_ch[S];
                    c_q  <= c_ch[S];
                    qp_q <= qp_ch[S];
                    qn_q <= qn_ch[S];
                    cnt  <= cnt + 1'b1;
                end
                ST_FIX: begin
                    quo     <= q_fix;
                    rem     <= MW'(rem_w);
                    rem_neg <= r_neg;
                    done    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/srt_div_chk.sv
module srt_div_chk #(
    parameter int MW = 56,
    parameter int S  = 4,
    parameter int QW = 56
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [QW-1:0] quo,
    input logic [MW-1:0] rem,
    input logic          rem_neg,
    input logic [MW-1:0] d_held
);

    localparam int ITERS = (MW + 2 * S - 1) / (2 * S);
    localparam int RCW   = $clog2(ITERS + 2) + 1;

    logic [RCW-1:0] run_cnt;
    logic [MW+1:0]  rem3;
    logic [MW+1:0]  d1;
    logic [MW+1:0]  d2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    always_comb begin
        rem3 = (MW+2)'(rem) * (MW+2)'(3);
        d1   = (MW+2)'(d_held);
        d2   = (MW+2)'(d_held) << 1;
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                   // R2
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == RCW'(ITERS + 1)));                        // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R3
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));                                        // R3
    AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem < d_held));                                     // R5
    AST_FLAG_HIGH_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rem_neg) |-> (rem3 >= d1));                          // R6
    AST_FLAG_LOW_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rem_neg) |-> (rem3 <= d2));                         // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quo) && $stable(rem) && $stable(rem_neg))); // R8

endmodule

bind srt_div srt_div_chk #(.MW(MW), .S(S), .QW(QW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .quo     (quo),
    .rem     (rem),
    .rem_neg (rem_neg),
    .d_held  (d_q)
);

// File: tb/srt_div_bench.sv
`timescale 1ns/1ps
module srt_div_bench;

    localparam int MW    = 20;
    localparam int S     = 3;
    localparam int ITERS = (MW + 2 * S - 1) / (2 * S);
    localparam int ND    = S * ITERS;
    localparam int QW    = 2 * ND;
    localparam logic [MW-1:0] ONE = MW'(1) << (MW - 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [MW-1:0] dividend;
    logic [MW-1:0] divisor;
    logic          busy;
    logic          done;
    logic [QW-1:0] quo;
    logic [MW-1:0] rem;
    logic          rem_neg;

    always #2 clk = ~clk;

    srt_div #(.MW(MW), .S(S)) u_srt_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dividend (dividend),
        .divisor  (divisor),
        .busy     (busy),
        .done     (done),
        .quo      (quo),
        .rem      (rem),
        .rem_neg  (rem_neg)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Behavioural reference: timing and exact integer results.
    bit             m_busy = 0;
    bit             m_done = 0;
    int             m_left = 0;
    bit             have_res = 0;
    logic [QW-1:0]  m_q, m_qp;
    logic [MW-1:0]  m_r, m_rp, m_d, m_dp;
    bit             m_eq, m_eqp, m_ign, m_ignp;
    bit             ign_mark = 0;
    logic [127:0]   big, qq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0; have_res = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; have_res = 1;
                    m_q = m_qp; m_r = m_rp; m_d = m_dp; m_eq = m_eqp; m_ign = m_ignp;
                end
            end else if (start) begin
                m_busy = 1;
                m_left = ITERS + 1;
                big    = 128'(dividend) << (2 * (ND - 1));
                qq     = big / 128'(divisor);
                m_qp   = QW'(qq);
                m_rp   = MW'(big - qq * 128'(divisor));
                m_dp   = divisor;
                m_eqp  = (dividend == divisor);
                m_ignp = ign_mark;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy === m_busy, "R2 busy", 128'(busy), 128'(m_busy));
            chk(done === m_done, "R3 done", 128'(done), 128'(m_done));
            if (m_done) begin
                chk(quo === m_q, m_ign ? "R7 quo" : (m_eq ? "R9 quo" : "R4 quo"),
                    128'(quo), 128'(m_q));
                chk(rem === m_r, m_eq ? "R9 rem" : "R5 rem", 128'(rem), 128'(m_r));
                if (rem_neg)
                    chk(3 * 128'(rem) >= 128'(m_d), "R6 flag high band",
                        128'(rem), 128'(m_d));
                else
                    chk(3 * 128'(rem) <= 2 * 128'(m_d), "R6 flag low band",
                        128'(rem), 128'(m_d));
            end else if (have_res) begin
                chk(quo === m_q, "R8 quo hold", 128'(quo), 128'(m_q));
                chk(rem === m_r, "R8 rem hold", 128'(rem), 128'(m_r));
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            bad++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            wrap_up();
        end
    end

    task automatic do_op(input logic [MW-1:0] x, input logic [MW-1:0] d, input bit ign);
        int w = 0;
        while (busy) @(negedge clk);
        ign_mark = ign;
        start = 1; dividend = x; divisor = d;
        @(negedge clk);
        start = 0;
        if (ign) begin
            // R7: a second start in the middle of the run must be ignored
            @(negedge clk);
            start = 1; dividend = ONE; divisor = ~x | ONE;
            @(negedge clk);
            start = 0;
        end
        while (!done && w < 100) begin
            @(negedge clk);
            w++;
        end
        if (w >= 100) chk(0, "R3 done timeout", 128'(w), 128'(ITERS + 1));
        @(negedge clk);
        ign_mark = 0;
    endtask

    function automatic logic [MW-1:0] rnd();
        return MW'($urandom) | ONE;
    endfunction

    initial begin
        rst_n = 0; start = 0; dividend = '0; divisor = '0;
        repeat (4) @(negedge clk);
        chk(busy === 1'b0, "R1 busy in reset", 128'(busy), 0);
        chk(done === 1'b0, "R1 done in reset", 128'(done), 0);
        chk(quo  === '0,   "R1 quo in reset", 128'(quo), 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy after reset", 128'(busy), 0);
        chk(rem  === '0,   "R1 rem after reset", 128'(rem), 0);

        do_op(ONE, ONE, 0);                        // R9 at 1.0
        do_op(~MW'(0), ~MW'(0), 0);                // R9 just below 2
        do_op(~MW'(0), ONE, 0);                    // R4 largest ratio
        do_op(ONE, ~MW'(0), 0);                    // R4 smallest ratio
        do_op(ONE | MW'(12345), ONE, 0);           // R4 divisor 1.0
        do_op(ONE | MW'(777), ~MW'(0), 0);         // R4 divisor near 2
        do_op(rnd(), rnd(), 1);                    // R7
        for (int i = 0; i < 6; i++) begin
            logic [MW-1:0] v = rnd();
            do_op(v, v, 0);                        // R9 random equal pair
        end
        for (int i = 0; i < 40; i++) do_op(rnd(), rnd(), 0);  // R4 R5 R6
        repeat (5) @(negedge clk);                 // R8 hold while idle
        wrap_up();
    end

endmodule